// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time-of-Day Counter

This block keeps a 64-bit time of day in nanoseconds for precision time protocols. A 32-bit phase accumulator adds a programmable addend on every reference clock cycle. Each time that sum overflows, the raw count advances by a programmable nominal step in nanoseconds. Software trims the addend to slow down or speed up the count without changing the reference clock. For an exact rate, the addend is set to ceil(2^32 × nominal / reference). The nominal frequency must be below the reference frequency and must divide 1 GHz evenly.

The reported time is the raw count plus a 64-bit two's-complement offset. A coarse step in time can therefore be applied by rewriting only the offset. Loading the raw count sets the time: it clears the offset and restarts the phase. All registers are reached over a small word bus with 32-bit halves. A 64-bit value is read low half first. A 64-bit value is written low half first, and the write takes effect on the high half.

Top module: `ftc_timebase`

## Requirements
- R1: After reset the raw count, offset, addend and phase are zero, the run bit is 0, the step field holds `RESET_STEP` (8), and `tod_ns` is 0.
- R2: A read pulse on `reg_rd` is answered one cycle later with `reg_rvalid` high and the word in `reg_rdata`. `reg_rvalid` is low in the cycle after any cycle without a read. Address map:
  - 0: control, with the run bit in bit 0 and the step in bits [15:8];
  - 1: addend;
  - 2: raw count low half;
  - 3: raw count high half;
  - 4: offset low half;
  - 5: offset high half.
  Addresses 6 and 7 read as zero, and writes to them change nothing.
- R3: In each cycle with the run bit set, the phase becomes (phase + addend) mod 2^32. When that sum carries out of bit 31, the raw count grows by the step in the same cycle, and by nothing otherwise.
- R4: While the run bit is 0, the raw count and the phase both hold their values. The phase is kept across a stop and a restart.
- R5: A write to address 2 only stages the low half and leaves the count unchanged. A write to address 3 loads the whole count from the staged low half and the written high half at once.
- R6: Loading the raw count clears the offset to zero and clears the phase to zero.
- R7: Reading address 2 captures the high half of the raw count in a shadow. A later read of address 3 returns that shadow, even if the count has changed in between.
- R8: A write to address 4 stages the offset low half. A write to address 5 commits the full offset. Offset reads return the committed value.
- R9: `tod_ns` equals (raw count + offset) mod 2^64, so an offset with all upper bits set acts as a negative value.
- R10: A load of the raw count in a cycle where the phase carries takes priority over the step: the count becomes exactly the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read response strobe, one cycle after `reg_rd` |
| tod_ns | output | 64 | Reported time: raw count plus offset |

## Verification
The assertions check these rules on every cycle:
- the one-cycle read response;
- that a stopped counter never moves;
- that a running counter moves by either zero or exactly one step;
- that a count load puts the written high half in place and clears the offset;
- that the offset moves only on its own commit or on a count load.

The exact number of steps after a run of given length is left to the bench scenarios. So are the phase that carries over between runs and the phase reset on load. The bench scenarios also cover the coherence of the shadow high half and the priority of a load over a simultaneous carry, both of which need a planned sequence of accesses.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    // Word addresses of the register bus
    typedef enum logic [2:0] {
        FTC_CTRL   = 3'd0,
        FTC_ADDEND = 3'd1,
        FTC_CNT_LO = 3'd2,
        FTC_CNT_HI = 3'd3,
        FTC_OFF_LO = 3'd4,
        FTC_OFF_HI = 3'd5
    } ftc_addr_e;

    // Control word layout: run bit and step field position
    localparam int unsigned FTC_RUN_BIT  = 0;
    localparam int unsigned FTC_STEP_LSB = 8;

endpackage

// File: rtl/ftc_phase_accum.sv
module ftc_phase_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [ACC_W-1:0] addend,
    output logic             carry
);

    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_state_t;

    acc_state_t s_d, s_q;
    logic [ACC_W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, s_q.phase} + {1'b0, addend};
        s_d   = s_q;
        carry = 1'b0;
        if (restart) begin
            s_d.phase = '0;
        end else if (run) begin
            s_d.phase = sum_w[ACC_W-1:0];
            carry     = sum_w[ACC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ftc_split_reg.sv
module ftc_split_reg #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic              clear,
    input  logic              adv_en,
    input  logic [FULL_W-1:0] adv_val,
    output logic [FULL_W-1:0] value
);

    typedef struct packed {
        logic [HALF_W-1:0] stage;
        logic [FULL_W-1:0] val;
    } split_state_t;

    split_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_lo) s_d.stage = wdata;
        // committed write wins over clear and over advance
        if (wr_hi)       s_d.val = {wdata, s_q.stage};
        else if (clear)  s_d.val = '0;
        else if (adv_en) s_d.val = s_q.val + adv_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.val;

endmodule

// File: rtl/ftc_bus_port.sv
module ftc_bus_port
    import ftc_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    localparam int unsigned CNT_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] ctrl_word,
    input  logic [REG_W-1:0] addend,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] off,
    output logic [REG_W-1:0] rdata,
    output logic             rvalid
);

    typedef struct packed {
        logic [REG_W-1:0] shadow_hi;
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } port_state_t;

    port_state_t s_d, s_q;
    logic [REG_W-1:0] word_w;

    always_comb begin
        case (addr)
            FTC_CTRL:   word_w = ctrl_word;
            FTC_ADDEND: word_w = addend;
            FTC_CNT_LO: word_w = cnt[REG_W-1:0];
            FTC_CNT_HI: word_w = s_q.shadow_hi;
            FTC_OFF_LO: word_w = off[REG_W-1:0];
            FTC_OFF_HI: word_w = off[CNT_W-1:REG_W];
            default:    word_w = '0;
        endcase
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = rd;
        if (rd) begin
            s_d.rdata = word_w;
            if (addr == FTC_CNT_LO) s_d.shadow_hi = cnt[CNT_W-1:REG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata  = s_q.rdata;
    assign rvalid = s_q.rvalid;

endmodule

// File: rtl/ftc_timebase.sv
module ftc_timebase
    import ftc_pkg::*;
#(
    parameter int unsigned REG_W      = 32,
    parameter int unsigned STEP_W     = 8,
    parameter int unsigned RESET_STEP = 8,
    localparam int unsigned CNT_W     = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             reg_rvalid,
    output logic [CNT_W-1:0] tod_ns
);

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic [REG_W-1:0]  addend;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic              wr_ctrl, wr_addend, wr_cnt_lo, wr_cnt_hi, wr_off_lo, wr_off_hi;
    logic              carry_w;
    logic              ctl_run;
    logic [STEP_W-1:0] ctl_step;
    logic [CNT_W-1:0]  step_ext;
    logic [CNT_W-1:0]  cnt_raw;
    logic [CNT_W-1:0]  off_raw;
    logic [REG_W-1:0]  ctrl_word;

    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == FTC_CTRL);
        wr_addend = reg_wr && (reg_addr == FTC_ADDEND);
        wr_cnt_lo = reg_wr && (reg_addr == FTC_CNT_LO);
        wr_cnt_hi = reg_wr && (reg_addr == FTC_CNT_HI);
        wr_off_lo = reg_wr && (reg_addr == FTC_OFF_LO);
        wr_off_hi = reg_wr && (reg_addr == FTC_OFF_HI);
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.run  = reg_wdata[FTC_RUN_BIT];
            cfg_d.step = reg_wdata[FTC_STEP_LSB +: STEP_W];
        end
        if (wr_addend) cfg_d.addend = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.run    <= 1'b0;
            cfg_q.step   <= STEP_W'(RESET_STEP);
            cfg_q.addend <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctl_run  = cfg_q.run;
    assign ctl_step = cfg_q.step;
    assign step_ext = {{(CNT_W-STEP_W){1'b0}}, cfg_q.step};

    always_comb begin
        ctrl_word                             = '0;
        ctrl_word[FTC_RUN_BIT]                = cfg_q.run;
        ctrl_word[FTC_STEP_LSB +: STEP_W]     = cfg_q.step;
    end

    ftc_phase_accum #(.ACC_W(REG_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_q.run),
        .restart (wr_cnt_hi),
        .addend  (cfg_q.addend),
        .carry   (carry_w)
    );

    ftc_split_reg #(.HALF_W(REG_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_cnt_lo),
        .wr_hi   (wr_cnt_hi),
        .wdata   (reg_wdata),
        .clear   (1'b0),
        .adv_en  (carry_w),
        .adv_val (step_ext),
        .value   (cnt_raw)
    );

    ftc_split_reg #(.HALF_W(REG_W)) u_offset (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_off_lo),
        .wr_hi   (wr_off_hi),
        .wdata   (reg_wdata),
        .clear   (wr_cnt_hi),
        .adv_en  (1'b0),
        .adv_val ('0),
        .value   (off_raw)
    );

    ftc_bus_port #(.REG_W(REG_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .ctrl_word (ctrl_word),
        .addend    (cfg_q.addend),
        .cnt       (cnt_raw),
        .off       (off_raw),
        .rdata     (reg_rdata),
        .rvalid    (reg_rvalid)
    );

    assign tod_ns = cnt_raw + off_raw;

endmodule

// File: rtl/ftc_timebase_chk.sv
module ftc_timebase_chk
    import ftc_pkg::*;
#(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned STEP_W = 8,
    localparam int unsigned CNT_W = 2 * REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [2:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              reg_rvalid,
    input logic              run,
    input logic [STEP_W-1:0] step,
    input logic [CNT_W-1:0]  cnt_raw,
    input logic [CNT_W-1:0]  off_raw
);

    logic             load_w;
    logic             off_commit_w;
    logic [CNT_W-1:0] step_wide;

    assign load_w       = reg_wr && (reg_addr == FTC_CNT_HI);
    assign off_commit_w = reg_wr && (reg_addr == FTC_OFF_HI);
    assign step_wide    = {{(CNT_W-STEP_W){1'b0}}, step};

    assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_no_rvalid_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_w) |=> $stable(cnt_raw));

    assert_zero_or_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_w) |=> ((cnt_raw == $past(cnt_raw)) ||
                              (cnt_raw == $past(cnt_raw) + $past(step_wide))));

    assert_load_takes_high_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (cnt_raw[CNT_W-1:REG_W] == $past(reg_wdata)));

    assert_load_clears_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (off_raw == '0));

    assert_offset_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && !off_commit_w) |=> $stable(off_raw));

endmodule

bind ftc_timebase ftc_timebase_chk #(.REG_W(REG_W), .STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .run        (ctl_run),
    .step       (ctl_step),
    .cnt_raw    (cnt_raw),
    .off_raw    (off_raw)
);

// File: tb/ftc_timebase_test.sv
module ftc_timebase_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [63:0] tod_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // requirement-level model of the programmer-visible state
    logic [63:0] m_cnt = '0;
    logic [63:0] m_off = '0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_add = '0;
    logic [63:0] m_step = 64'd8;

    ftc_timebase uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .tod_ns     (tod_ns)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected read words as responses arrive
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected response got %h expected none", reg_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read got %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic chk_tod(input string t);
        checks++;
        if (tod_ns !== m_cnt + m_off) begin
            errors++;
            $display("FAIL %s: tod got %h expected %h", t, tod_ns, m_cnt + m_off);
        end
    endtask

    task automatic load_cnt(input logic [63:0] v);
        bus_wr(3'd2, v[31:0]);
        bus_wr(3'd3, v[63:32]);
        m_cnt = v; m_off = '0; m_acc = '0;
    endtask

    task automatic load_off(input logic [63:0] v);
        bus_wr(3'd4, v[31:0]);
        bus_wr(3'd5, v[63:32]);
        m_off = v;
    endtask

    // run for k idle cycles between start and stop: k+1 counting edges
    task automatic run_for(input int k);
        automatic logic [63:0] tot;
        bus_wr(3'd0, {16'd0, m_step[7:0], 8'h01});
        repeat (k) @(negedge clk);
        bus_wr(3'd0, {16'd0, m_step[7:0], 8'h00});
        tot = {32'd0, m_acc} + 64'(k + 1) * {32'd0, m_add};
        m_cnt = m_cnt + (tot >> 32) * m_step;
        m_acc = tot[31:0];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        automatic logic [63:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_tod("R1");
        bus_rd(3'd0, 32'h0000_0800, "R1");
        bus_rd(3'd1, 32'h0, "R1");
        bus_rd(3'd2, 32'h0, "R1");
        bus_rd(3'd3, 32'h0, "R1");
        bus_rd(3'd4, 32'h0, "R1");
        bus_rd(3'd6, 32'h0, "R2");

        // R2 control/addend programming, step 10
        m_step = 64'd10;
        bus_wr(3'd0, 32'h0000_0A00);
        bus_rd(3'd0, 32'h0000_0A00, "R2");
        m_add = 32'h6000_0000;
        bus_wr(3'd1, m_add);
        bus_rd(3'd1, m_add, "R2");

        // R5 staging of the low half
        bus_wr(3'd2, 32'h1111_2222);
        bus_rd(3'd2, 32'h0, "R5");
        bus_rd(3'd3, 32'h0, "R5");
        chk_tod("R5");
        bus_wr(3'd3, 32'h0000_0003);
        m_cnt = 64'h0000_0003_1111_2222;
        bus_rd(3'd2, 32'h1111_2222, "R5");
        bus_rd(3'd3, 32'h0000_0003, "R5");
        chk_tod("R9");

        // R8 offset staging and commit
        bus_wr(3'd4, 32'h0000_0100);
        chk_tod("R8");
        bus_wr(3'd5, 32'h0);
        m_off = 64'h100;
        chk_tod("R8");
        bus_rd(3'd4, 32'h0000_0100, "R8");
        bus_rd(3'd5, 32'h0, "R8");

        // R9 negative offset
        load_off(64'hFFFF_FFFF_FFFF_FFFB);
        chk_tod("R9");

        // R4 stopped counter holds
        repeat (20) @(negedge clk);
        chk_tod("R4");
        bus_rd(3'd2, m_cnt[31:0], "R4");
        bus_rd(3'd3, m_cnt[63:32], "R4");

        // R6 load clears offset
        load_cnt(64'h0000_0010_0000_0000);
        bus_rd(3'd4, 32'h0, "R6");
        bus_rd(3'd5, 32'h0, "R6");
        chk_tod("R6");

        // R3 counting: 16 edges at 3/8 -> 6 steps
        run_for(15);
        chk_tod("R3");
        bus_rd(3'd2, m_cnt[31:0], "R3");
        bus_rd(3'd3, m_cnt[63:32], "R3");
        // R4 phase kept across stop/start
        run_for(4);
        chk_tod("R4");
        run_for(1);
        chk_tod("R4");

        // R6 load clears phase: 2 edges from zero give no carry
        load_cnt(64'h0000_0020_0000_0000);
        run_for(1);
        chk_tod("R6");

        // R7 shadow coherence
        keep = m_cnt;
        bus_rd(3'd2, keep[31:0], "R7");
        load_cnt(64'h0000_0077_0000_0005);
        bus_rd(3'd3, keep[63:32], "R7");
        bus_rd(3'd2, 32'h0000_0005, "R7");
        bus_rd(3'd3, 32'h0000_0077, "R7");

        // R10 load wins over a carry while running
        m_add = 32'hFFFF_FFFF;
        bus_wr(3'd1, m_add);
        bus_wr(3'd0, 32'h0000_0A01);
        repeat (3) @(negedge clk);
        bus_wr(3'd2, 32'h0000_1234);
        bus_wr(3'd3, 32'h0000_0040);
        bus_wr(3'd0, 32'h0000_0A00);
        m_cnt = 64'h0000_0040_0000_1234; m_off = '0; m_acc = 32'hFFFF_FFFF;
        chk_tod("R10");

        // R2 unmapped writes ignored
        bus_wr(3'd7, 32'hDEAD_BEEF);
        bus_wr(3'd6, 32'hDEAD_BEEF);
        bus_rd(3'd0, 32'h0000_0A00, "R2");
        bus_rd(3'd1, m_add, "R2");
        bus_rd(3'd7, 32'h0, "R2");
        chk_tod("R2");

        // R9 wrap of the sum
        load_cnt(64'hFFFF_FFFF_FFFF_FFF0);
        load_off(64'h20);
        chk_tod("R9");

        drain();
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule